// File: doc/BRIEF.md
# Display Link Reset Trigger Sequencer

This block runs the sequence that ends with a link-level reset trigger being sent to an attached display. The trigger goes out on the first data lane of a serial display link. Software starts the sequence with a one-shot write to a control bit. A mode bit picks one of two policies:

- **Immediate:** drop new traffic at once, and let the transfer on the link and the already-scheduled transfers finish.
- **Frame-synchronized:** let the video frame now in flight complete, and drop new traffic after that.

Once the link is quiet, the block pulses flush strobes to the TX FIFO, RX FIFO, line buffers and synchronization buffers, all in one cycle. It then hands the programmed 8-bit trigger pattern to the lane's escape transmitter over a valid/ready handshake. Last, it holds the engine datapath in reset for a fixed number of cycles. The configuration registers are never reset by this block.

The control bit reads back as busy. It clears itself when the escape transmitter accepts the trigger. A write that arrives while a sequence is running has no effect. If frame-synchronized mode is asked for while no virtual channel is active in video mode, the block raises an error flag and runs the immediate policy instead.

Top module: `dsi_rst_trigger_seq`

## Requirements
- R1: After reset, all flush strobes, `engine_rst`, `esc_valid`, `drop_new_traffic`, `trig_busy` and `sync_fallback_err` are 0.
- R2: In immediate mode, `drop_new_traffic` and `trig_busy` are 1 in the cycle after the accepted write. No flush strobe fires while `sched_xfer_active` is 1 or `sched_count` is nonzero.
- R3: In synchronized mode with a frame active, `drop_new_traffic` stays 0 and no flush fires until `vp_eof` is seen. `drop_new_traffic` rises in the cycle after `vp_eof`.
- R4: A write with `sync_mode`=1 while every bit of `vc_video_active` is 0 sets `sync_fallback_err` to 1 and follows the immediate policy without waiting for `vp_eof`. Any accepted write recomputes the flag.
- R5: When the link is quiet, `flush_txfifo`, `flush_rxfifo`, `flush_linebuf` and `flush_syncbuf` are all 1 for exactly one cycle, in the cycle before `esc_valid` first rises. That cycle follows the cycle in which the drain condition was first met.
- R6: `esc_valid` stays 1 until `esc_ready`. While it waits, `esc_pattern` holds bits [31:24] of `trig_cfg_word` as they were at the accepted write. Later changes to `trig_cfg_word` have no effect on it.
- R7: `trig_busy` drops to 0 in the cycle after the `esc_valid`/`esc_ready` handshake.
- R8: `engine_rst` is 1 for exactly ENG_RST_CYCLES cycles (4 by default), starting the cycle after the handshake. After that, `drop_new_traffic` returns to 0.
- R9: A `trig_reset_wr` pulse while a sequence is running changes no output: neither the pattern nor `sync_fallback_err`, and no extra sequence is started.
- R10: In synchronized mode with a video channel active and `vp_frame_active`=0, the sequence proceeds without waiting for `vp_eof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_cfg_word | input | 32 | Trigger configuration word; reset pattern in bits [31:24] |
| trig_reset_wr | input | 1 | One-cycle write of 1 to the reset-trigger control bit |
| sync_mode | input | 1 | 0 = immediate policy, 1 = frame-synchronized policy |
| sched_xfer_active | input | 1 | A transfer is currently on the link |
| sched_count | input | 4 | Number of transfers already scheduled |
| vp_frame_active | input | 1 | Video port is inside a frame |
| vp_eof | input | 1 | End-of-frame pulse from the video port |
| vc_video_active | input | 4 | Per virtual channel: in video mode and active |
| esc_ready | input | 1 | Escape transmitter accepts the trigger |
| trig_busy | output | 1 | Read-back of the self-clearing control bit |
| sync_fallback_err | output | 1 | Synchronized mode was requested with no active video channel |
| drop_new_traffic | output | 1 | Discard unscheduled TX, RX and video-port data |
| flush_txfifo | output | 1 | One-cycle TX FIFO flush |
| flush_rxfifo | output | 1 | One-cycle RX FIFO flush |
| flush_linebuf | output | 1 | One-cycle line buffer flush |
| flush_syncbuf | output | 1 | One-cycle sync buffer flush |
| engine_rst | output | 1 | Engine datapath reset (registers untouched) |
| esc_valid | output | 1 | Trigger request to the lane escape transmitter |
| esc_pattern | output | 8 | Trigger pattern carried with the request |

## Verification
The bench stalls the escape transmitter and rewrites the configuration word during the wait. A design that sampled the pattern live, or dropped the request early, would send the wrong byte or lose the trigger. It keeps the scheduler busy with a nonzero count after the link transfer ends. A sequencer that looked only at the active flag would flush too early. It repeats the software write in mid-sequence with an illegal mode. A design that re-armed would set the error flag or emit a second flush and trigger, and the scoreboard catches that as an unexpected event. Synchronized mode is run with a frame in flight, with no frame, and with no video channel. Wrong gating would show up as early discard, a hang waiting for an end-of-frame pulse, or a missing fallback flag.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE     = 3'd0,
    SQ_WAIT_EOF = 3'd1,
    SQ_DRAIN    = 3'd2,
    SQ_FLUSH    = 3'd3,
    SQ_SEND     = 3'd4,
    SQ_ENG_RST  = 3'd5
  } seq_state_e;

  localparam int unsigned FLUSH_TX   = 0;
  localparam int unsigned FLUSH_RX   = 1;
  localparam int unsigned FLUSH_LINE = 2;
  localparam int unsigned FLUSH_SYNC = 3;
  localparam int unsigned NUM_FLUSH  = 4;

endpackage

// File: rtl/rstseq_mode_sel.sv
module rstseq_mode_sel #(
  parameter int unsigned NUM_VC = 4
) (
  input  logic              sync_req,
  input  logic [NUM_VC-1:0] vc_active,
  output logic              use_sync,
  output logic              fallback
);

  logic any_video;

  assign any_video = |vc_active;
  assign use_sync  = sync_req & any_video;
  assign fallback  = sync_req & ~any_video;

endmodule

// File: rtl/rstseq_quiet_det.sv
module rstseq_quiet_det #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             xfer_active,
  input  logic [CNT_W-1:0] sched_count,
  input  logic             frame_active,
  input  logic             eof,
  output logic             link_quiet,
  output logic             frame_done
);

  assign link_quiet = ~xfer_active & (sched_count == '0);
  assign frame_done = eof | ~frame_active;

endmodule

// File: rtl/rstseq_flush_gen.sv
module rstseq_flush_gen
  import rstseq_pkg::*;
#(
  parameter int unsigned N = NUM_FLUSH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire,
  output logic [N-1:0] strobe
);

  for (genvar i = 0; i < N; i++) begin : g_strobe
    assign strobe[i] = fire;

    // R5
    flush_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe[i] |=> !strobe[i]);
  end

endmodule

// File: rtl/rstseq_esc_req.sv
module rstseq_esc_req #(
  parameter int unsigned PAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PAT_W-1:0] pat_in,
  input  logic             send,
  input  logic             ready,
  output logic             valid,
  output logic [PAT_W-1:0] pattern,
  output logic             done
);

  logic [PAT_W-1:0] pat_q, pat_d;
  logic             pat_en;

  assign pat_en = load;

  always_comb begin
    pat_d = pat_q;
    if (pat_en) pat_d = pat_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pat_q <= '0;
    else if (pat_en) pat_q <= pat_d;
  end

  assign valid   = send;
  assign pattern = pat_q;
  assign done    = send & ready;

  // R6
  esc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(pattern)));

endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
  import rstseq_pkg::*;
#(
  parameter int unsigned ENG_RST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_wr,
  input  logic use_sync,
  input  logic fallback,
  input  logic link_quiet,
  input  logic frame_done,
  input  logic esc_done,
  output logic accept,
  output logic flush_fire,
  output logic send,
  output logic eng_rst,
  output logic drop,
  output logic busy,
  output logic err
);

  localparam int unsigned CW = $clog2(ENG_RST_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(ENG_RST_CYCLES - 1);

  seq_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic busy_q, busy_d, err_q, err_d;
  logic cnt_en;

  assign accept = (st_q == SQ_IDLE) & sw_wr;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SQ_IDLE:     if (sw_wr) st_d = use_sync ? SQ_WAIT_EOF : SQ_DRAIN;
      SQ_WAIT_EOF: if (frame_done) st_d = SQ_DRAIN;
      SQ_DRAIN:    if (link_quiet) st_d = SQ_FLUSH;
      SQ_FLUSH:    st_d = SQ_SEND;
      SQ_SEND:     if (esc_done) st_d = SQ_ENG_RST;
      SQ_ENG_RST:  if (cnt_q == LAST) st_d = SQ_IDLE;
      default:     st_d = SQ_IDLE;
    endcase
  end

  assign cnt_en = (st_q == SQ_ENG_RST) | esc_done;

  always_comb begin
    cnt_d = cnt_q;
    if (esc_done)                cnt_d = '0;
    else if (st_q == SQ_ENG_RST) cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    busy_d = busy_q;
    err_d  = err_q;
    if (accept) begin
      busy_d = 1'b1;
      err_d  = fallback;
    end else if (esc_done) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      busy_q <= busy_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign flush_fire = (st_q == SQ_FLUSH);
  assign send       = (st_q == SQ_SEND);
  assign eng_rst    = (st_q == SQ_ENG_RST);
  assign drop       = (st_q == SQ_DRAIN) | (st_q == SQ_FLUSH) |
                      (st_q == SQ_SEND)  | (st_q == SQ_ENG_RST);
  assign busy       = busy_q;
  assign err        = err_q;

  // R5
  flush_then_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_fire |=> send);

  // R8
  eng_rst_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_rst) |-> $past(esc_done));

  // R7
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(esc_done));

  // R9
  no_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sw_wr) |=> $stable(err));

  // R2
  flush_needs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_fire |-> $past(link_quiet));

endmodule

// File: rtl/dsi_rst_trigger_seq.sv
module dsi_rst_trigger_seq
  import rstseq_pkg::*;
#(
  parameter int unsigned CFG_W          = 32,
  parameter int unsigned PAT_LSB        = 24,
  parameter int unsigned PAT_W          = 8,
  parameter int unsigned CNT_W          = 4,
  parameter int unsigned NUM_VC         = 4,
  parameter int unsigned ENG_RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  trig_cfg_word,
  input  logic              trig_reset_wr,
  input  logic              sync_mode,
  input  logic              sched_xfer_active,
  input  logic [CNT_W-1:0]  sched_count,
  input  logic              vp_frame_active,
  input  logic              vp_eof,
  input  logic [NUM_VC-1:0] vc_video_active,
  input  logic              esc_ready,
  output logic              trig_busy,
  output logic              sync_fallback_err,
  output logic              drop_new_traffic,
  output logic              flush_txfifo,
  output logic              flush_rxfifo,
  output logic              flush_linebuf,
  output logic              flush_syncbuf,
  output logic              engine_rst,
  output logic              esc_valid,
  output logic [PAT_W-1:0]  esc_pattern
);

  logic use_sync, fallback, link_quiet, frame_done;
  logic accept, flush_fire, send, esc_done;
  logic [NUM_FLUSH-1:0] strobes;

  rstseq_mode_sel #(.NUM_VC(NUM_VC)) u_mode (
    .sync_req  (sync_mode),
    .vc_active (vc_video_active),
    .use_sync  (use_sync),
    .fallback  (fallback)
  );

  rstseq_quiet_det #(.CNT_W(CNT_W)) u_quiet (
    .xfer_active  (sched_xfer_active),
    .sched_count  (sched_count),
    .frame_active (vp_frame_active),
    .eof          (vp_eof),
    .link_quiet   (link_quiet),
    .frame_done   (frame_done)
  );

  rstseq_ctrl #(.ENG_RST_CYCLES(ENG_RST_CYCLES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_wr      (trig_reset_wr),
    .use_sync   (use_sync),
    .fallback   (fallback),
    .link_quiet (link_quiet),
    .frame_done (frame_done),
    .esc_done   (esc_done),
    .accept     (accept),
    .flush_fire (flush_fire),
    .send       (send),
    .eng_rst    (engine_rst),
    .drop       (drop_new_traffic),
    .busy       (trig_busy),
    .err        (sync_fallback_err)
  );

  rstseq_flush_gen #(.N(NUM_FLUSH)) u_flush (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (flush_fire),
    .strobe (strobes)
  );

  rstseq_esc_req #(.PAT_W(PAT_W)) u_esc (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .pat_in  (trig_cfg_word[PAT_LSB +: PAT_W]),
    .send    (send),
    .ready   (esc_ready),
    .valid   (esc_valid),
    .pattern (esc_pattern),
    .done    (esc_done)
  );

  assign flush_txfifo  = strobes[FLUSH_TX];
  assign flush_rxfifo  = strobes[FLUSH_RX];
  assign flush_linebuf = strobes[FLUSH_LINE];
  assign flush_syncbuf = strobes[FLUSH_SYNC];

  // R8
  no_reset_during_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    engine_rst |-> !esc_valid);

  // R3
  sync_wait_no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_busy && !drop_new_traffic) |-> !flush_txfifo);

endmodule

// File: tb/dsi_rst_trigger_seq_tb.sv
module dsi_rst_trigger_seq_tb_top;

  localparam int ENG = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [31:0] trig_cfg_word;
  logic trig_reset_wr, sync_mode, sched_xfer_active, vp_frame_active, vp_eof, esc_ready;
  logic [3:0] sched_count, vc_video_active;
  logic trig_busy, sync_fallback_err, drop_new_traffic;
  logic flush_txfifo, flush_rxfifo, flush_linebuf, flush_syncbuf, engine_rst, esc_valid;
  logic [7:0] esc_pattern;

  int tests = 0;
  int fails = 0;
  int eng_len = 0;
  logic [15:0] exp_q[$];

  always #5 clk = ~clk;

  dsi_rst_trigger_seq #(.ENG_RST_CYCLES(ENG)) dut_i (
    .clk(clk), .rst_n(rst_n), .trig_cfg_word(trig_cfg_word),
    .trig_reset_wr(trig_reset_wr), .sync_mode(sync_mode),
    .sched_xfer_active(sched_xfer_active), .sched_count(sched_count),
    .vp_frame_active(vp_frame_active), .vp_eof(vp_eof),
    .vc_video_active(vc_video_active), .esc_ready(esc_ready),
    .trig_busy(trig_busy), .sync_fallback_err(sync_fallback_err),
    .drop_new_traffic(drop_new_traffic), .flush_txfifo(flush_txfifo),
    .flush_rxfifo(flush_rxfifo), .flush_linebuf(flush_linebuf),
    .flush_syncbuf(flush_syncbuf), .engine_rst(engine_rst),
    .esc_valid(esc_valid), .esc_pattern(esc_pattern)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard: kind in [15:8] (1 flush vector, 2 trigger pattern, 3 engine reset length)
  task automatic push_seq(input logic [7:0] pat);
    exp_q.push_back({8'h01, 8'h0f});
    exp_q.push_back({8'h02, pat});
    exp_q.push_back({8'h03, 8'(ENG)});
  endtask

  task automatic match(input logic [15:0] got, input string req);
    logic [15:0] e;
    if (exp_q.size() == 0) begin
      chk(1'b0, {req, " unexpected event"}, {16'h0, got}, 32'h0);
    end else begin
      e = exp_q.pop_front();
      chk(got == e, req, {16'h0, got}, {16'h0, e});
    end
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (flush_txfifo | flush_rxfifo | flush_linebuf | flush_syncbuf)
        match({8'h01, 4'h0, flush_syncbuf, flush_linebuf, flush_rxfifo, flush_txfifo}, "R5 flush set");
      if (esc_valid && esc_ready)
        match({8'h02, esc_pattern}, "R6 trigger pattern");
      if (engine_rst) eng_len++;
      else if (eng_len != 0) begin
        match({8'h03, 8'(eng_len)}, "R8 engine reset length");
        eng_len = 0;
      end
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic pulse_wr();
    trig_reset_wr = 1'b1; step(); trig_reset_wr = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) step();
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hang expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; trig_cfg_word = 32'h0; trig_reset_wr = 1'b0; sync_mode = 1'b0;
    sched_xfer_active = 1'b0; sched_count = 4'd0; vp_frame_active = 1'b0; vp_eof = 1'b0;
    vc_video_active = 4'h0; esc_ready = 1'b0;
    settle(3);
    @(negedge clk);
    chk({flush_txfifo, flush_rxfifo, flush_linebuf, flush_syncbuf, engine_rst, esc_valid,
         drop_new_traffic, trig_busy, sync_fallback_err} == 9'b0, "R1 reset state",
        {23'h0, flush_txfifo, flush_rxfifo, flush_linebuf, flush_syncbuf, engine_rst, esc_valid,
         drop_new_traffic, trig_busy, sync_fallback_err}, 32'h0);
    step(); rst_n = 1'b1; settle(2);

    // Scenario A: immediate mode, busy scheduler, stalled escape transmitter
    trig_cfg_word = 32'hA500_1234; sched_xfer_active = 1'b1; sched_count = 4'd2;
    push_seq(8'hA5);
    pulse_wr();
    @(negedge clk);
    chk(drop_new_traffic == 1'b1, "R2 drop after write", {31'h0, drop_new_traffic}, 32'h1);
    chk(trig_busy == 1'b1, "R2 busy after write", {31'h0, trig_busy}, 32'h1);
    trig_cfg_word = 32'h3C00_0000; sync_mode = 1'b1; vc_video_active = 4'h0;
    step(); pulse_wr(); sync_mode = 1'b0;
    settle(3);
    sched_xfer_active = 1'b0; step();
    @(negedge clk);
    chk(flush_txfifo == 1'b0, "R2 no flush with pending count", {31'h0, flush_txfifo}, 32'h0);
    sched_count = 4'd0; step();
    @(negedge clk);
    chk(flush_txfifo && flush_syncbuf && !esc_valid, "R5 flush in cycle after drain",
        {30'h0, flush_txfifo, esc_valid}, 32'h2);
    @(negedge clk);
    chk(esc_valid && !flush_txfifo, "R5 request after flush", {30'h0, esc_valid, flush_txfifo}, 32'h2);
    settle(3);
    @(negedge clk);
    chk(esc_valid && esc_pattern == 8'hA5, "R6 held pattern while stalled", {24'h0, esc_pattern}, 32'hA5);
    chk(sync_fallback_err == 1'b0, "R9 mid-sequence write ignored", {31'h0, sync_fallback_err}, 32'h0);
    step(); esc_ready = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(engine_rst && !trig_busy, "R7 busy cleared at handshake", {30'h0, engine_rst, trig_busy}, 32'h2);
    settle(ENG + 2); esc_ready = 1'b0;
    @(negedge clk);
    chk(!engine_rst && !drop_new_traffic, "R8 back to idle", {30'h0, engine_rst, drop_new_traffic}, 32'h0);
    chk(exp_q.size() == 0, "R9 single sequence only", exp_q.size(), 32'h0);

    // Scenario B: synchronized mode with a frame in flight
    trig_cfg_word = 32'h5A00_0000; sync_mode = 1'b1; vc_video_active = 4'h2;
    vp_frame_active = 1'b1; esc_ready = 1'b1;
    push_seq(8'h5A);
    pulse_wr(); settle(4);
    @(negedge clk);
    chk(!drop_new_traffic && !flush_txfifo && trig_busy, "R3 waiting for end of frame",
        {30'h0, drop_new_traffic, trig_busy}, 32'h1);
    vp_eof = 1'b1; step(); vp_eof = 1'b0; vp_frame_active = 1'b0;
    @(negedge clk);
    chk(drop_new_traffic == 1'b1, "R3 drop after end of frame", {31'h0, drop_new_traffic}, 32'h1);
    settle(ENG + 6);
    chk(sync_fallback_err == 1'b0 && exp_q.size() == 0, "R3 sequence completed",
        {31'h0, sync_fallback_err}, 32'h0);

    // Scenario C: synchronized request with no video channel -> fallback
    trig_cfg_word = 32'hC300_0000; vc_video_active = 4'h0; vp_frame_active = 1'b1;
    push_seq(8'hC3);
    pulse_wr();
    @(negedge clk);
    chk(sync_fallback_err && drop_new_traffic, "R4 fallback to immediate",
        {30'h0, sync_fallback_err, drop_new_traffic}, 32'h3);
    settle(ENG + 6);
    chk(exp_q.size() == 0, "R4 finished without end of frame", exp_q.size(), 32'h0);

    // Scenario D: synchronized, video channel active, no frame in flight
    trig_cfg_word = 32'h9600_0000; vc_video_active = 4'h8; vp_frame_active = 1'b0;
    push_seq(8'h96);
    pulse_wr();
    settle(ENG + 6);
    chk(sync_fallback_err == 1'b0, "R4 flag recomputed", {31'h0, sync_fallback_err}, 32'h0);
    chk(exp_q.size() == 0, "R10 no-frame sync proceeds", exp_q.size(), 32'h0);
    chk(!trig_busy, "R7 idle at end", {31'h0, trig_busy}, 32'h0);

    summary();
  end

endmodule